// File: doc/BRIEF.md
# Multiplexed Address/Data Pin Interface

This block connects a 16-bit internal CPU bus to two 8-bit external pin groups, called port A and port B, plus two control pins. When the block runs in an expanded mode, the same port pins carry address and data at different times. An external bus clock sets the timing: the pins carry the address while that clock is low and the data while it is high. In wide mode a 16-bit word uses both ports at once. In narrow mode a word is split into two byte transfers on port A, high byte first, and the CPU is held busy until both transfers are done. In single-chip mode the pins are plain general-purpose I/O, each pin set by its own data bit and direction bit.

The operating mode is read from two mode pins in the first clock after reset is released, and it then stays fixed until the next reset. Control pin 0 reports free CPU cycles in the expanded modes. Control pin 1 can carry a pipe-status bit once software enables it.

Registers are reached with a register access: `cpu_reg` high and the offset on `cpu_addr[2:0]`. Register write data is taken from `cpu_wdata[7:0]`, and read data comes back on `cpu_rdata[7:0]` one cycle later.

Top module: `xbus_mux`

## Requirements
- R1: The mode is captured from `mode_pins` in the first clock cycle after reset is released. Bit 1 set means expanded mode, and bit 0 set (with bit 1 set) means wide rather than narrow. Later changes on `mode_pins` have no effect until the next reset.
- R2: While reset is held, every output enable is low, `cpu_busy` is low and `cpu_rdata` is zero.
- R3: In single-chip mode each pin of port A, port B and the control pins drives its data bit when its direction bit is 1. The register offsets are: 0 port A data, 1 port B data, 2 port A direction, 3 port B direction, 4 control-pin data (2 bits), 5 control-pin direction (2 bits), 6 pipe enable (bit 0). Reading a data register returns the data bit where the pin is an output and the pin level where it is an input.
- R4: During a bus address phase (bus clock low), port A drives address bits 15:8 and port B drives bits 7:0, with all 16 output enables high for reads and for writes alike.
- R5: In wide mode, the data phase of a word write drives `cpu_wdata[15:8]` on port A and `cpu_wdata[7:0]` on port B.
- R6: In the data phase of a read, no port pin is driven. The pins are sampled when the bus clock falls at the end of that phase, and a wide word read returns {port A, port B}.
- R7: In narrow mode a word access takes two data phases on port A, high byte first and low byte second. Port B is never driven during a data phase, and `cpu_busy` stays high until the second phase ends.
- R8: A byte access (`cpu_word` low) uses port A alone in either expanded mode. A write drives `cpu_wdata[7:0]`, and a read returns {8'h00, port A}.
- R9: In the expanded modes control pin 0 is an output that follows `cpu_free`. In single-chip mode it is general-purpose I/O.
- R10: When the pipe-enable bit is set, control pin 1 is an output that follows `cpu_pipe`. When the bit is clear, the pin is general-purpose I/O.
- R11: Once the final data phase of an access ends, `cpu_busy` and all port output enables are low by the next clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_pins | input | 2 | Mode strap, captured after reset |
| eclk | input | 1 | External bus clock level (low = address, high = data) |
| cpu_req | input | 1 | Access request, one cycle |
| cpu_reg | input | 1 | Request targets the internal registers |
| cpu_addr | input | 16 | Access address / register offset |
| cpu_wdata | input | 16 | Write data |
| cpu_rnw | input | 1 | 1 = read, 0 = write |
| cpu_word | input | 1 | 1 = 16-bit access, 0 = byte |
| cpu_free | input | 1 | Current CPU cycle is a free cycle |
| cpu_pipe | input | 1 | Pipe-status bit |
| cpu_rdata | output | 16 | Read data |
| cpu_busy | output | 1 | Bus access in progress |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output values |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output values |
| pb_oe | output | 8 | Port B output enables |
| pe_in | input | 2 | Control pin levels |
| pe_out | output | 2 | Control pin output values |
| pe_oe | output | 2 | Control pin output enables |

## Verification
The bench checks the order of the two narrow-mode data phases and the lane used for each byte. A design that swaps the halves, or that puts the low byte on port B, returns a byte-swapped read or drives the wrong pins. It confirms that reads still drive the address with every enable high and then release the pins in the data phase; a design that drops the enables or drives a read's data phase would fight the external device. It also changes the mode pins after reset to catch a mode that is not latched, and it checks the mixed pin and latch readback of general-purpose registers for bits whose direction is split.

// File: rtl/xbus_pkg.sv
// Shared definitions for the multiplexed pin interface.
// Assumes register offsets are decoded from the low three address bits.
package xbus_pkg;
    typedef enum logic [2:0] {
        SEL_PA_DAT  = 3'd0,
        SEL_PB_DAT  = 3'd1,
        SEL_PA_DIR  = 3'd2,
        SEL_PB_DIR  = 3'd3,
        SEL_CP_DAT  = 3'd4,
        SEL_CP_DIR  = 3'd5,
        SEL_CTL     = 3'd6,
        SEL_NONE    = 3'd7
    } xbus_sel_e;

    localparam int CP_W = 2;
endpackage

// File: rtl/xbus_mode_latch.sv
// Captures the operating mode from the strap pins in the first cycle after reset.
// Assumes the strap is stable around reset release; holds the mode until the next reset.
module xbus_mode_latch (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_pins,
    output logic       mode_valid,
    output logic       expanded,
    output logic       wide
);
    logic [1:0] mode_q;

    // Capture the strap once, on the first clock with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_valid <= 1'b0;
            mode_q     <= 2'b00;
        end else if (!mode_valid) begin
            mode_valid <= 1'b1;
            mode_q     <= mode_pins;
        end
    end

    assign expanded = mode_valid & mode_q[1];
    assign wide     = mode_q[0];

    // R1: the captured mode never changes once valid
    a_r1_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_valid && $past(mode_valid)) |-> $stable(mode_q));
endmodule

// File: rtl/xbus_gpio_regs.sv
// Holds the data and direction registers and the pipe enable; registered readback.
// Assumes single-cycle register accesses; reads mix the latch and pin level per direction bit.
module xbus_gpio_regs
    import xbus_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [2:0]      sel,
    input  logic [BW-1:0]   wdata,
    input  logic [BW-1:0]   pa_in,
    input  logic [BW-1:0]   pb_in,
    input  logic [CP_W-1:0] cp_in,
    output logic [BW-1:0]   pa_dat,
    output logic [BW-1:0]   pa_dir,
    output logic [BW-1:0]   pb_dat,
    output logic [BW-1:0]   pb_dir,
    output logic [CP_W-1:0] cp_dat,
    output logic [CP_W-1:0] cp_dir,
    output logic            pipe_en,
    output logic [BW-1:0]   rd_data
);
    xbus_sel_e sel_e;
    logic [BW-1:0] rd_next;

    assign sel_e = xbus_sel_e'(sel);

    // Register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa_dat  <= '0;
            pa_dir  <= '0;
            pb_dat  <= '0;
            pb_dir  <= '0;
            cp_dat  <= '0;
            cp_dir  <= '0;
            pipe_en <= 1'b0;
        end else if (wr_en) begin
            case (sel_e)
                SEL_PA_DAT: pa_dat  <= wdata;
                SEL_PB_DAT: pb_dat  <= wdata;
                SEL_PA_DIR: pa_dir  <= wdata;
                SEL_PB_DIR: pb_dir  <= wdata;
                SEL_CP_DAT: cp_dat  <= wdata[CP_W-1:0];
                SEL_CP_DIR: cp_dir  <= wdata[CP_W-1:0];
                SEL_CTL:    pipe_en <= wdata[0];
                default: ;
            endcase
        end
    end

    // Readback value selection.
    always_comb begin
        rd_next = '0;
        case (sel_e)
            SEL_PA_DAT: rd_next = (pa_dat & pa_dir) | (pa_in & ~pa_dir);
            SEL_PB_DAT: rd_next = (pb_dat & pb_dir) | (pb_in & ~pb_dir);
            SEL_PA_DIR: rd_next = pa_dir;
            SEL_PB_DIR: rd_next = pb_dir;
            SEL_CP_DAT: rd_next[CP_W-1:0] = (cp_dat & cp_dir) | (cp_in & ~cp_dir);
            SEL_CP_DIR: rd_next[CP_W-1:0] = cp_dir;
            SEL_CTL:    rd_next[0] = pipe_en;
            default: ;
        endcase
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    // R3: a direction write for port A is visible on the next cycle
    a_r3_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == 3'd2) |=> (pa_dir == $past(wdata)));
endmodule

// File: rtl/xbus_seq.sv
// Runs one external bus access: the address phase, then one or two data phases timed by the bus clock.
// Assumes the bus clock is slower than clk; its level is registered once and its falling edge ends each phase.
module xbus_seq #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          eclk,
    input  logic          start,
    input  logic          wide,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rnw,
    input  logic          word,
    input  logic [DW/2-1:0] pa_in,
    input  logic [DW/2-1:0] pb_in,
    output logic          busy,
    output logic [DW-1:0] rdata,
    output logic [DW/2-1:0] pa_val,
    output logic [DW/2-1:0] pa_en,
    output logic [DW/2-1:0] pb_val,
    output logic [DW/2-1:0] pb_en
);
    localparam int BW = DW / 2;

    logic          ph, act, started, beat, rnw_q, word_q;
    logic [DW-1:0] a_q, w_q;
    logic          fall, addr_ph, data_ph, drive_dat;
    logic [BW-1:0] lane_a;

    assign fall    = ~eclk & ph;
    assign addr_ph = started & ~ph;
    assign data_ph = started & ph;

    // Access state, phase tracking and read-data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            act     <= 1'b0;
            started <= 1'b0;
            beat    <= 1'b0;
            rnw_q   <= 1'b0;
            word_q  <= 1'b0;
            a_q     <= '0;
            w_q     <= '0;
            rdata   <= '0;
        end else begin
            ph <= eclk;
            if (!act && start) begin
                act     <= 1'b1;
                started <= 1'b0;
                beat    <= 1'b0;
                a_q     <= addr;
                w_q     <= wdata;
                rnw_q   <= rnw;
                word_q  <= word;
            end else if (act && fall) begin
                if (!started) begin
                    started <= 1'b1;
                end else begin
                    if (rnw_q) begin
                        if (word_q && wide)  rdata <= {pa_in, pb_in};
                        else if (word_q && !beat) rdata[DW-1:BW] <= pa_in;
                        else if (word_q)     rdata[BW-1:0] <= pa_in;
                        else                 rdata <= {{BW{1'b0}}, pa_in};
                    end
                    if (word_q && !wide && !beat) begin
                        beat <= 1'b1;
                    end else begin
                        act     <= 1'b0;
                        started <= 1'b0;
                        beat    <= 1'b0;
                    end
                end
            end
        end
    end

    // Byte placed on port A during a data phase.
    always_comb begin
        if (word_q && (wide || !beat)) lane_a = w_q[DW-1:BW];
        else                           lane_a = w_q[BW-1:0];
    end

    assign drive_dat = data_ph & ~rnw_q;

    // Pin values and enables for the address and data phases.
    always_comb begin
        pa_val = addr_ph ? a_q[DW-1:BW] : lane_a;
        pb_val = addr_ph ? a_q[BW-1:0]  : w_q[BW-1:0];
        pa_en  = (addr_ph | drive_dat) ? '1 : '0;
        pb_en  = (addr_ph | (drive_dat & word_q & wide)) ? '1 : '0;
    end

    assign busy = act;

    // R4: every enable is high in an address phase
    a_r4_addr_all_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !ph) |-> (&pa_en && &pb_en));
    // R6: a read data phase drives nothing
    a_r6_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (started && ph && rnw_q) |-> (pa_en == '0 && pb_en == '0));
    // R7: a second beat exists only for narrow word accesses
    a_r7_beat_narrow: assert property (@(posedge clk) disable iff (!rst_n)
        beat |-> (word_q && !wide && act));
    // R11: phases only run inside an active access
    a_r11_started_in_act: assert property (@(posedge clk) disable iff (!rst_n)
        started |-> act);
endmodule

// File: rtl/xbus_mux.sv
// Top of the multiplexed pin interface: routes the pins to general-purpose I/O or to the bus sequencer by mode.
// Assumes requests are one-cycle pulses; bus requests made while busy or outside the expanded modes are dropped.
module xbus_mux
    import xbus_pkg::*;
#(
    parameter int DW       = 16,
    parameter bit HAS_PIPE = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_pins,
    input  logic            eclk,
    input  logic            cpu_req,
    input  logic            cpu_reg,
    input  logic [DW-1:0]   cpu_addr,
    input  logic [DW-1:0]   cpu_wdata,
    input  logic            cpu_rnw,
    input  logic            cpu_word,
    input  logic            cpu_free,
    input  logic            cpu_pipe,
    output logic [DW-1:0]   cpu_rdata,
    output logic            cpu_busy,
    input  logic [DW/2-1:0] pa_in,
    output logic [DW/2-1:0] pa_out,
    output logic [DW/2-1:0] pa_oe,
    input  logic [DW/2-1:0] pb_in,
    output logic [DW/2-1:0] pb_out,
    output logic [DW/2-1:0] pb_oe,
    input  logic [CP_W-1:0] pe_in,
    output logic [CP_W-1:0] pe_out,
    output logic [CP_W-1:0] pe_oe
);
    localparam int BW = DW / 2;

    logic          mode_valid, expanded, wide;
    logic          reg_wr, reg_rd, bus_start, src_reg;
    logic [BW-1:0] pa_dat, pa_dir, pb_dat, pb_dir, reg_rd_data;
    logic [CP_W-1:0] cp_dat, cp_dir;
    logic          pipe_en;
    logic [DW-1:0] bus_rdata;
    logic [BW-1:0] bus_pa, bus_pa_en, bus_pb, bus_pb_en;
    logic          pipe_drive;

    assign reg_wr    = mode_valid & cpu_req & cpu_reg & ~cpu_rnw;
    assign reg_rd    = mode_valid & cpu_req & cpu_reg &  cpu_rnw;
    assign bus_start = expanded & cpu_req & ~cpu_reg;

    xbus_mode_latch u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_pins  (mode_pins),
        .mode_valid (mode_valid),
        .expanded   (expanded),
        .wide       (wide)
    );

    xbus_gpio_regs #(.BW(BW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .rd_en   (reg_rd),
        .sel     (cpu_addr[2:0]),
        .wdata   (cpu_wdata[BW-1:0]),
        .pa_in   (pa_in),
        .pb_in   (pb_in),
        .cp_in   (pe_in),
        .pa_dat  (pa_dat),
        .pa_dir  (pa_dir),
        .pb_dat  (pb_dat),
        .pb_dir  (pb_dir),
        .cp_dat  (cp_dat),
        .cp_dir  (cp_dir),
        .pipe_en (pipe_en),
        .rd_data (reg_rd_data)
    );

    xbus_seq #(.DW(DW)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .eclk   (eclk),
        .start  (bus_start),
        .wide   (wide),
        .addr   (cpu_addr),
        .wdata  (cpu_wdata),
        .rnw    (cpu_rnw),
        .word   (cpu_word),
        .pa_in  (pa_in),
        .pb_in  (pb_in),
        .busy   (cpu_busy),
        .rdata  (bus_rdata),
        .pa_val (bus_pa),
        .pa_en  (bus_pa_en),
        .pb_val (bus_pb),
        .pb_en  (bus_pb_en)
    );

    // Track whether the latest read came from a register or the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         src_reg <= 1'b0;
        else if (reg_rd)    src_reg <= 1'b1;
        else if (bus_start && !cpu_busy) src_reg <= 1'b0;
    end

    assign cpu_rdata = src_reg ? {{BW{1'b0}}, reg_rd_data} : bus_rdata;

    generate
        if (HAS_PIPE) begin : g_pipe
            assign pipe_drive = pipe_en;
        end else begin : g_nopipe
            assign pipe_drive = 1'b0;
        end
    endgenerate

    // Pin routing by mode; everything is an input until the mode is known.
    always_comb begin
        pa_out = '0; pa_oe = '0;
        pb_out = '0; pb_oe = '0;
        pe_out = '0; pe_oe = '0;
        if (mode_valid) begin
            if (expanded) begin
                pa_out = bus_pa; pa_oe = bus_pa_en;
                pb_out = bus_pb; pb_oe = bus_pb_en;
                pe_out[0] = cpu_free; pe_oe[0] = 1'b1;
            end else begin
                pa_out = pa_dat; pa_oe = pa_dir;
                pb_out = pb_dat; pb_oe = pb_dir;
                pe_out[0] = cp_dat[0]; pe_oe[0] = cp_dir[0];
            end
            if (pipe_drive) begin
                pe_out[1] = cpu_pipe; pe_oe[1] = 1'b1;
            end else begin
                pe_out[1] = cp_dat[1]; pe_oe[1] = cp_dir[1];
            end
        end
    end

    // R2: no pin is driven before the mode is latched
    a_r2_quiet_unlatched: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_valid |-> (pa_oe == '0 && pb_oe == '0 && pe_oe == '0));
    // R11: an idle bus drives no port pin
    a_r11_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
        (expanded && !cpu_busy) |-> (pa_oe == '0 && pb_oe == '0));
    // R9: control pin 0 is an output in the expanded modes
    a_r9_noacc_driven: assert property (@(posedge clk) disable iff (!rst_n)
        expanded |-> pe_oe[0]);
endmodule

// File: tb/sim_xbus_mux.sv
module sim_xbus_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_pins = 2'b00;
    logic        eclk = 1'b1;
    logic        cpu_req = 1'b0, cpu_reg = 1'b0, cpu_rnw = 1'b0, cpu_word = 1'b0;
    logic        cpu_free = 1'b0, cpu_pipe = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_busy;
    logic [7:0]  pa_in = '0, pa_out, pa_oe, pb_in = '0, pb_out, pb_oe;
    logic [1:0]  pe_in = '0, pe_out, pe_oe;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    xbus_mux u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mix(input logic [7:0] dat, input logic [7:0] dir, input logic [7:0] pin);
        return (dat & dir) | (pin & ~dir);
    endfunction

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; mode_pins = m; eclk = 1'b1;
        repeat (3) @(negedge clk);
        chk(pa_oe == 0 && pb_oe == 0 && pe_oe == 0, "R2 oe in reset", {pa_oe, pb_oe}, 16'h0);
        chk(cpu_busy == 0 && cpu_rdata == 0, "R2 busy/rdata in reset", cpu_rdata, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] off, input logic [7:0] v);
        cpu_req = 1; cpu_reg = 1; cpu_rnw = 0; cpu_addr = {13'h0, off}; cpu_wdata = {8'h0, v};
        @(negedge clk);
        cpu_req = 0; cpu_reg = 0;
    endtask

    task automatic reg_rd(input logic [2:0] off, input logic [7:0] exp, input string tag);
        cpu_req = 1; cpu_reg = 1; cpu_rnw = 1; cpu_addr = {13'h0, off};
        @(negedge clk);
        cpu_req = 0; cpu_reg = 0;
        chk(cpu_rdata == {8'h0, exp}, tag, cpu_rdata, {8'h0, exp});
    endtask

    // One bus access with the bench acting as the bus clock and the external device.
    task automatic bus_txn(input logic [15:0] a, input logic [15:0] wd, input bit rnw, input bit word, input bit wide);
        int beats;
        logic [15:0] exp_rd;
        logic [7:0] pa_exp;
        logic [7:0] ra, rb;
        beats = (word && !wide) ? 2 : 1;
        exp_rd = 16'h0;
        eclk = 1'b1;
        @(negedge clk);
        cpu_req = 1; cpu_reg = 0; cpu_addr = a; cpu_wdata = wd; cpu_rnw = rnw; cpu_word = word;
        @(negedge clk);
        cpu_req = 0; eclk = 1'b0;
        for (int b = 0; b < beats; b++) begin
            cpu_free = 1'($urandom);
            @(negedge clk);
            chk(pa_out == a[15:8] && pb_out == a[7:0], "R4 address on pins", {pa_out, pb_out}, a);
            chk(pa_oe == 8'hFF && pb_oe == 8'hFF, "R4 all enables in address phase", {pa_oe, pb_oe}, 16'hFFFF);
            chk(cpu_busy == 1'b1, "R7 busy during access", {15'h0, cpu_busy}, 16'h1);
            chk(pe_oe[0] && pe_out[0] == cpu_free, "R9 free-cycle pin", {14'h0, pe_oe[0], pe_out[0]}, {14'h0, 1'b1, cpu_free});
            eclk = 1'b1;
            @(negedge clk);
            if (rnw) begin
                chk(pa_oe == 0 && pb_oe == 0, "R6 read data phase undriven", {pa_oe, pb_oe}, 16'h0);
            end else begin
                if (word && wide) pa_exp = wd[15:8];
                else if (word)    pa_exp = (b == 0) ? wd[15:8] : wd[7:0];
                else              pa_exp = wd[7:0];
                chk(pa_oe == 8'hFF && pa_out == pa_exp, word ? (wide ? "R5 wide write port A" : "R7 narrow write lane") : "R8 byte write port A",
                    {pa_oe, pa_out}, {8'hFF, pa_exp});
                if (word && wide)
                    chk(pb_oe == 8'hFF && pb_out == wd[7:0], "R5 wide write port B", {pb_oe, pb_out}, {8'hFF, wd[7:0]});
                else
                    chk(pb_oe == 8'h00, word ? "R7 port B idle in narrow data" : "R8 port B idle for byte", {8'h0, pb_oe}, 16'h0);
            end
            ra = 8'($urandom); rb = 8'($urandom);
            pa_in = ra; pb_in = rb;
            if (word && wide)  exp_rd = {ra, rb};
            else if (word)     begin if (b == 0) exp_rd[15:8] = ra; else exp_rd[7:0] = ra; end
            else               exp_rd = {8'h0, ra};
            eclk = 1'b0;
        end
        @(negedge clk);
        chk(cpu_busy == 0 && pa_oe == 0 && pb_oe == 0, "R11 release after last phase", {cpu_busy, 7'h0, pa_oe}, 16'h0);
        if (rnw)
            chk(cpu_rdata == exp_rd, word ? (wide ? "R6 wide read data" : "R7 narrow read order") : "R8 byte read data", cpu_rdata, exp_rd);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);

        // Single-chip general-purpose I/O.
        do_reset(2'b00);
        mode_pins = 2'b11; // R1: late strap change must not matter
        for (int i = 0; i < 20; i++) begin
            logic [7:0] da, ra, db, rb;
            logic [1:0] de, re;
            da = 8'($urandom); ra = 8'($urandom); db = 8'($urandom); rb = 8'($urandom);
            de = 2'($urandom); re = 2'($urandom);
            reg_wr(3'd2, da); reg_wr(3'd0, ra); reg_wr(3'd3, db); reg_wr(3'd1, rb);
            reg_wr(3'd5, {6'h0, de}); reg_wr(3'd4, {6'h0, re});
            chk(pa_oe == da && pa_out == ra, "R3 port A drive (R1 mode held)", {pa_oe, pa_out}, {da, ra});
            chk(pb_oe == db && pb_out == rb, "R3 port B drive", {pb_oe, pb_out}, {db, rb});
            chk(pe_oe == de && pe_out == re, "R9 control pin 0 as GPIO in single-chip", {14'h0, pe_oe}, {14'h0, de});
            pa_in = 8'($urandom); pb_in = 8'($urandom); pe_in = 2'($urandom);
            reg_rd(3'd0, mix(ra, da, pa_in), "R3 port A readback");
            reg_rd(3'd1, mix(rb, db, pb_in), "R3 port B readback");
            reg_rd(3'd4, {6'h0, mix({6'h0, re}, {6'h0, de}, {6'h0, pe_in})}[1:0] == 2'b00 ? 8'h00 : mix({6'h0, re}, {6'h0, de}, {6'h0, pe_in}), "R3 control readback");
            reg_rd(3'd2, da, "R3 direction A readback");
        end
        // Pipe-status pin.
        reg_wr(3'd5, 8'h00);
        reg_wr(3'd6, 8'h01);
        cpu_pipe = 1'b1; #1;
        chk(pe_oe[1] && pe_out[1], "R10 pipe pin high", {14'h0, pe_oe[1], pe_out[1]}, 16'h3);
        cpu_pipe = 1'b0; #1;
        chk(pe_oe[1] && !pe_out[1], "R10 pipe pin low", {14'h0, pe_oe[1], pe_out[1]}, 16'h2);
        reg_rd(3'd6, 8'h01, "R10 pipe enable readback");
        reg_wr(3'd6, 8'h00);
        chk(pe_oe[1] == 1'b0, "R10 pipe off returns pin to GPIO", {15'h0, pe_oe[1]}, 16'h0);

        // Expanded narrow.
        do_reset(2'b10);
        mode_pins = 2'b00; // R1: ignored after latch
        bus_txn(16'hA55A, 16'h1234, 1'b0, 1'b1, 1'b0);
        bus_txn(16'h00FF, 16'h0000, 1'b1, 1'b1, 1'b0);
        bus_txn(16'hFF00, 16'h00C3, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 12; i++)
            bus_txn(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b0);

        // Expanded wide.
        do_reset(2'b11);
        bus_txn(16'h8001, 16'hBEEF, 1'b0, 1'b1, 1'b1);
        bus_txn(16'h7FFE, 16'h0000, 1'b1, 1'b1, 1'b1);
        bus_txn(16'h1357, 16'h0000, 1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 12; i++)
            bus_txn(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b1);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule